// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block is the eight-bit status register of a simple asynchronous/synchronous serial port. It collects transmit and receive conditions reported by the serial engine and presents them as one byte to a CPU, to the serial engine and to interrupt logic. Five of the bits are sticky flags. Hardware events set them. Software clears them through a two-step handshake: the CPU must first read the register while the flag shows 1, and only then does a write of 0 to that bit position clear it.

Two further bits mirror level conditions from the serial engine and cannot be written by the CPU. The lowest bit is a plain read/write bit that holds the multiprocessor bit value for the next transmitted frame. A combinational summary output tells the interrupt logic whether any receive error flag is set. Reset, and a standby request, load the value 0x84.

Top module: `serial_status_reg`

## Requirements
- R1: While rst_n is low, or in the cycle after standby is high at a clock edge, the register reads 0x84 and every read-arm bit is clear.
- R2: The bit layout is: 7 transmit-buffer-empty, 6 receive-buffer-full, 5 overrun error, 4 framing error, 3 parity error, 2 transmission done, 1 received multiprocessor bit, 0 multiprocessor bit to send.
- R3: A one-cycle evt_tx_load pulse sets bit 7 at the next clock edge.
- R4: Bit 7 is set at every clock edge at which tx_enable is low.
- R5: One-cycle pulses on evt_rx_done, evt_overrun, evt_frame and evt_parity set bits 6, 5, 4 and 3 respectively, and these bits stay set after the pulse ends.
- R6: A write of 0 to a sticky bit (bits 7 to 3) that has not been read as 1 since it was last cleared leaves it at 1.
- R7: A register read (sel and rd high at a clock edge) arms every sticky bit that is 1; a later write (sel and wr high) with a 0 in an armed bit position clears that bit and its arm.
- R8: Writing 1 to a sticky bit position changes neither the bit nor its arm.
- R9: When a set event and a clearing write hit the same bit at the same edge, the bit stays 1 and its arm is dropped, so a fresh read is needed before it can be cleared.
- R10: Bits 2 and 1 take the values of lvl_tx_end and lvl_rx_mpb one cycle later; CPU writes to those positions have no effect.
- R11: A write loads wdata bit 0 into bit 0.
- R12: err_any is 1 exactly when at least one of bits 5, 4 or 3 is 1.
- R13: rdata shows the register value while sel and rd are high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Standby entry, reloads the reset value |
| sel | input | 1 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| evt_tx_load | input | 1 | Transmit data moved into the shift register (pulse) |
| tx_enable | input | 1 | Transmitter enable control level |
| evt_rx_done | input | 1 | Received byte complete (pulse) |
| evt_overrun | input | 1 | Receive overrun (pulse) |
| evt_frame | input | 1 | Framing error (pulse) |
| evt_parity | input | 1 | Parity error (pulse) |
| lvl_tx_end | input | 1 | Transmission finished level |
| lvl_rx_mpb | input | 1 | Received multiprocessor bit level |
| status | output | 8 | Current register value |
| err_any | output | 1 | Any receive error flag set |

## Verification
The assertions watch, on every cycle, that an arm bit never exists without its flag, that an unarmed flag never drops, that a set event always leaves its flag at 1, that an armed clear empties both flag and arm, that the level bits track their inputs and that standby restores 0x84. What only the bench scenarios show is the full handshake order: that a read really is needed before a write of 0 takes effect, that the arm is lost after a collision with a set event, that writes of 1 leave everything alone, and that the read-back path and the error summary match the flags across a long sweep of mixed events and CPU accesses.

// File: rtl/ssr_pkg.sv
// Package: bit positions and reset value shared by the status register modules.
// Assumes an eight-bit register with the sticky flags in one contiguous range.
package ssr_pkg;
    localparam int REG_W   = 8;
    localparam int B_TXE   = 7;   // transmit buffer empty
    localparam int B_RXF   = 6;   // receive buffer full
    localparam int B_OVR   = 5;   // overrun error
    localparam int B_FRM   = 4;   // framing error
    localparam int B_PAR   = 3;   // parity error
    localparam int B_TEND  = 2;   // transmission done (level)
    localparam int B_MPB   = 1;   // received multiprocessor bit (level)
    localparam int B_MPBT  = 0;   // multiprocessor bit to send
    localparam int CLR_LO  = B_PAR;
    localparam int CLR_HI  = B_TXE;
    localparam int N_CLR   = CLR_HI - CLR_LO + 1;
    localparam logic [REG_W-1:0] INIT_VAL = 8'h84;
endpackage

// File: rtl/ssr_sticky_flag.sv
// One software-clearable flag with its read-arm bit.
// Does: sets on a hardware event, arms when read as 1, clears on a write of 0
// only when armed; a set event in the same cycle as a clear wins and drops the arm.
// Assumes: rd_arm and wr_zero are already qualified by register select.
module ssr_sticky_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic set_evt,
    input  logic rd_arm,
    input  logic wr_zero,
    output logic flag,
    output logic armed
);

    logic clr_hit;
    assign clr_hit = wr_zero & armed;

    // Update flag and arm state from reset, events and the CPU handshake.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            flag  <= RST_VAL;
            armed <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
            if (clr_hit)
                armed <= 1'b0;
            else if (rd_arm && flag)
                armed <= 1'b1;
        end else if (clr_hit) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (rd_arm && flag) begin
            armed <= 1'b1;
        end
    end

    // An arm bit only exists while its flag is set.
    assert_arm_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> flag);

    // An unarmed set flag cannot be dropped by the CPU.
    assert_unarmed_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !armed && flag) |=> flag);

    // A hardware set always leaves the flag at 1.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && set_evt) |=> flag);

    // An armed clear without a competing set empties flag and arm.
    assert_armed_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !set_evt && armed && wr_zero) |=> (!flag && !armed));

endmodule

// File: rtl/ssr_line_bits.sv
// The three non-sticky bits: two read-only level mirrors and one read/write bit.
// Does: samples the transmission-done and received-multiprocessor levels each cycle,
// and loads the bit to send from CPU writes.
// Assumes: mpbt_we is already qualified by register select.
module ssr_line_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic lvl_end,
    input  logic lvl_mpb,
    input  logic mpbt_we,
    input  logic mpbt_wd,
    input  logic ro_wr,
    output logic tx_end,
    output logic rx_mpb,
    output logic tx_mpb
);
    import ssr_pkg::*;

    // Sample the level inputs; reset loads the register's reset pattern.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            tx_end <= INIT_VAL[B_TEND];
            rx_mpb <= INIT_VAL[B_MPB];
        end else begin
            tx_end <= lvl_end;
            rx_mpb <= lvl_mpb;
        end
    end

    // Hold the multiprocessor bit to send, written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n || init)
            tx_mpb <= INIT_VAL[B_MPBT];
        else if (mpbt_we)
            tx_mpb <= mpbt_wd;
    end

    // Level bits track their inputs even when the CPU writes their positions.
    assert_level_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && ro_wr) |=> (tx_end == $past(lvl_end) && rx_mpb == $past(lvl_mpb)));

    // A write lands in the send bit.
    assert_mpbt_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && mpbt_we) |=> (tx_mpb == $past(mpbt_wd)));

endmodule

// File: rtl/ssr_cpu_port.sv
// CPU access decode for the status register.
// Does: turns select and strobes into a read-arm pulse, a per-bit write-zero mask
// for the sticky flags, a send-bit write, and the read-back mux.
// Assumes: strobes are single-cycle and synchronous to clk.
module ssr_cpu_port
    import ssr_pkg::*;
(
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W-1:0]  status,
    output logic              rd_arm,
    output logic [N_CLR-1:0]  zero_mask,
    output logic              mpbt_we,
    output logic              mpbt_wd,
    output logic              ro_wr,
    output logic [REG_W-1:0]  rdata
);

    logic wr_hit;

    // Qualify the strobes with the select.
    always_comb begin
        rd_arm = sel & rd;
        wr_hit = sel & wr;
    end

    // Write of 0 per sticky bit; writes of 1 produce no request.
    always_comb begin
        zero_mask = wr_hit ? ~wdata[CLR_HI:CLR_LO] : '0;
    end

    // Send-bit load and a marker for writes touching the read-only positions.
    always_comb begin
        mpbt_we = wr_hit;
        mpbt_wd = wdata[B_MPBT];
        ro_wr   = wr_hit & (wdata[B_TEND:B_MPB] != 2'b00);
    end

    // Read-back: the register while read, zero otherwise.
    always_comb begin
        rdata = rd_arm ? status : '0;
    end

endmodule

// File: rtl/serial_status_reg.sv
// Status register of a serial port.
// Does: holds five sticky flags with a read-then-write-zero clear handshake,
// two read-only level mirrors and one read/write bit, and summarises the
// receive error flags for interrupt logic.
// Assumes: event inputs are single-cycle pulses except tx_enable and the lvl_* inputs.
module serial_status_reg
    import ssr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic              sel,
    input  logic              rd,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              evt_tx_load,
    input  logic              tx_enable,
    input  logic              evt_rx_done,
    input  logic              evt_overrun,
    input  logic              evt_frame,
    input  logic              evt_parity,
    input  logic              lvl_tx_end,
    input  logic              lvl_rx_mpb,
    output logic [REG_W-1:0]  status,
    output logic              err_any
);

    logic              rd_arm;
    logic [N_CLR-1:0]  zero_mask;
    logic              mpbt_we;
    logic              mpbt_wd;
    logic              ro_wr;
    logic [N_CLR-1:0]  set_vec;
    logic [N_CLR-1:0]  flags;
    logic [N_CLR-1:0]  arms;
    logic              tx_end;
    logic              rx_mpb;
    logic              tx_mpb;

    // Map engine events onto the sticky bit positions (index 0 = lowest sticky bit).
    always_comb begin
        set_vec[B_TXE - CLR_LO] = evt_tx_load | ~tx_enable;
        set_vec[B_RXF - CLR_LO] = evt_rx_done;
        set_vec[B_OVR - CLR_LO] = evt_overrun;
        set_vec[B_FRM - CLR_LO] = evt_frame;
        set_vec[B_PAR - CLR_LO] = evt_parity;
    end

    ssr_cpu_port u_port (
        .sel       (sel),
        .rd        (rd),
        .wr        (wr),
        .wdata     (wdata),
        .status    (status),
        .rd_arm    (rd_arm),
        .zero_mask (zero_mask),
        .mpbt_we   (mpbt_we),
        .mpbt_wd   (mpbt_wd),
        .ro_wr     (ro_wr),
        .rdata     (rdata)
    );

    for (genvar i = 0; i < N_CLR; i++) begin : g_sticky
        ssr_sticky_flag #(
            .RST_VAL (INIT_VAL[CLR_LO + i])
        ) u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .init    (standby),
            .set_evt (set_vec[i]),
            .rd_arm  (rd_arm),
            .wr_zero (zero_mask[i]),
            .flag    (flags[i]),
            .armed   (arms[i])
        );
    end

    ssr_line_bits u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (standby),
        .lvl_end (lvl_tx_end),
        .lvl_mpb (lvl_rx_mpb),
        .mpbt_we (mpbt_we),
        .mpbt_wd (mpbt_wd),
        .ro_wr   (ro_wr),
        .tx_end  (tx_end),
        .rx_mpb  (rx_mpb),
        .tx_mpb  (tx_mpb)
    );

    // Assemble the register image.
    always_comb begin
        status                = '0;
        status[CLR_HI:CLR_LO] = flags;
        status[B_TEND]        = tx_end;
        status[B_MPB]         = rx_mpb;
        status[B_MPBT]        = tx_mpb;
    end

    // Summarise the receive error flags for interrupt logic.
    always_comb begin
        err_any = status[B_OVR] | status[B_FRM] | status[B_PAR];
    end

    // Standby restores the reset image with no arms left.
    assert_standby_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (status == INIT_VAL && arms == '0));

endmodule

// File: tb/serial_status_reg_bench.sv
`timescale 1ns/1ps
module serial_status_reg_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       evt_tx_load = 1'b0, tx_enable = 1'b0;
    logic       evt_rx_done = 1'b0, evt_overrun = 1'b0, evt_frame = 1'b0, evt_parity = 1'b0;
    logic       lvl_tx_end = 1'b1, lvl_rx_mpb = 1'b0;
    logic [7:0] status;
    logic       err_any;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // expected state, built from the requirements
    logic [7:3] m_flag;
    logic [7:3] m_arm;
    logic       m_tend, m_mpb, m_mpbt;

    always #4 clk = ~clk;

    serial_status_reg u_serial_status_reg (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .sel(sel), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata),
        .evt_tx_load(evt_tx_load), .tx_enable(tx_enable),
        .evt_rx_done(evt_rx_done), .evt_overrun(evt_overrun),
        .evt_frame(evt_frame), .evt_parity(evt_parity),
        .lvl_tx_end(lvl_tx_end), .lvl_rx_mpb(lvl_rx_mpb),
        .status(status), .err_any(err_any)
    );

    function automatic logic [7:0] m_img();
        return {m_flag, m_tend, m_mpb, m_mpbt};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // advance the expected state by one clock edge using the present inputs
    task automatic model_edge();
        logic [7:3] pulse;
        pulse = {1'b0, evt_rx_done, evt_overrun, evt_frame, evt_parity};
        if (!rst_n || standby) begin
            m_flag = 5'b10000; m_arm = '0;
            m_tend = 1'b1; m_mpb = 1'b0; m_mpbt = 1'b0;
        end else begin
            for (int b = 3; b <= 7; b++) begin
                logic s, c, r;
                s = (b == 7) ? (evt_tx_load | ~tx_enable) : pulse[b];
                c = sel & wr & ~wdata[b] & m_arm[b];
                r = sel & rd & m_flag[b];
                if (s) begin
                    m_flag[b] = 1'b1;
                    if (c) m_arm[b] = 1'b0;
                    else if (r) m_arm[b] = 1'b1;
                end else if (c) begin
                    m_flag[b] = 1'b0; m_arm[b] = 1'b0;
                end else if (r) begin
                    m_arm[b] = 1'b1;
                end
            end
            m_tend = lvl_tx_end;
            m_mpb  = lvl_rx_mpb;
            if (sel && wr) m_mpbt = wdata[0];
        end
    endtask

    // one clock: check read-back, take the edge, drop one-shot inputs, check outputs
    task automatic cycle(input string req);
        #1;
        chk({req, " R13 rdata"}, rdata, (sel && rd) ? m_img() : 8'h00);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        sel = 1'b0; rd = 1'b0; wr = 1'b0; wdata = 8'h00;
        evt_tx_load = 1'b0; evt_rx_done = 1'b0; evt_overrun = 1'b0;
        evt_frame = 1'b0; evt_parity = 1'b0; standby = 1'b0;
        chk(req, status, m_img());
        chk({req, " R12 err_any"}, {7'd0, err_any},
            {7'd0, m_flag[5] | m_flag[4] | m_flag[3]});
    endtask

    task automatic do_read(input string req);
        sel = 1'b1; rd = 1'b1; cycle(req);
    endtask

    task automatic do_write(input string req, input logic [7:0] v);
        sel = 1'b1; wr = 1'b1; wdata = v; cycle(req);
    endtask

    initial begin
        @(negedge clk);
        m_flag = 5'b10000; m_arm = '0; m_tend = 1'b1; m_mpb = 1'b0; m_mpbt = 1'b0;
        rst_n = 1'b0;
        repeat (3) cycle("R1 reset");
        chk("R1 reset image", status, 8'h84);
        rst_n = 1'b1;
        cycle("R4 tx disabled keeps bit7");
        chk("R4 bit7 set while disabled", status, 8'h84);
        tx_enable = 1'b1;
        cycle("idle");

        // R6: write 0 without a prior read
        do_write("R6 unarmed write0", 8'h00);
        chk("R6 bit7 kept", status & 8'h80, 8'h80);
        // R7: read then write 0
        do_read("R7 arm read");
        do_write("R7 armed clear", 8'h7F);
        chk("R7 bit7 cleared", status & 8'h80, 8'h00);

        // R3: load pulse sets bit7
        evt_tx_load = 1'b1; cycle("R3 load pulse");
        chk("R3 bit7 set", status & 8'h80, 8'h80);

        // R5, R2, R6, R8, R7 for each receive flag
        for (int b = 3; b <= 6; b++) begin
            case (b)
                6: evt_rx_done = 1'b1;
                5: evt_overrun = 1'b1;
                4: evt_frame   = 1'b1;
                default: evt_parity = 1'b1;
            endcase
            cycle("R5 pulse");
            cycle("R5 sticky");
            chk("R2 R5 bit position", status & (8'h1 << b), 8'h1 << b);
            do_write("R6 unarmed", ~(8'h1 << b));
            chk("R6 kept", status & (8'h1 << b), 8'h1 << b);
            do_read("R7 read");
            do_write("R8 write ones", 8'hFF);
            chk("R8 kept", status & (8'h1 << b), 8'h1 << b);
            do_write("R7 clear", ~(8'h1 << b));
            chk("R7 cleared", status & (8'h1 << b), 8'h00);
        end

        // R9: set collides with clear
        evt_rx_done = 1'b1; cycle("R9 set");
        do_read("R9 arm");
        sel = 1'b1; wr = 1'b1; wdata = 8'hBF; evt_rx_done = 1'b1;
        cycle("R9 collide");
        chk("R9 set wins", status & 8'h40, 8'h40);
        do_write("R9 arm dropped", 8'hBF);
        chk("R9 needs new read", status & 8'h40, 8'h40);
        do_read("R9 reread");
        do_write("R9 clear after reread", 8'hBF);
        chk("R9 cleared", status & 8'h40, 8'h00);

        // R10: level bits, writes to their positions ignored
        for (int k = 0; k < 4; k++) begin
            lvl_tx_end = k[0]; lvl_rx_mpb = k[1];
            do_write("R10 level follow", {5'b11111, ~k[0], ~k[1], 1'b0});
            chk("R10 level bits", status & 8'h06, {5'd0, k[0], k[1], 1'b0});
        end

        // R11: send bit write
        do_write("R11 send bit 1", 8'hF9);
        chk("R11 send bit", status & 8'h01, 8'h01);
        do_write("R11 send bit 0", 8'hF8);
        chk("R11 send bit", status & 8'h01, 8'h00);

        // R1: standby reload
        evt_overrun = 1'b1; cycle("R1 prep");
        standby = 1'b1; cycle("R1 standby");
        chk("R1 standby image", status, 8'h84);

        // sweep R7 R9 R12 R13: mixed events and accesses against the model
        for (int k = 0; k < 3000; k++) begin
            logic [11:0] u;
            u = 12'(k * 1103 + 17);
            sel         = (k % 7) != 0;
            rd          = u[0] ^ u[3];
            wr          = u[1] & ~u[4];
            wdata       = 8'(k * 37 + 5);
            evt_rx_done = u[2] & u[5];
            evt_overrun = u[6] & u[7] & u[8];
            evt_frame   = u[9] & u[10] & ~u[2];
            evt_parity  = u[11] & u[5] & u[3];
            evt_tx_load = u[7] & u[1];
            tx_enable   = (k % 11) != 0;
            lvl_tx_end  = u[6];
            lvl_rx_mpb  = u[8] ^ u[0];
            standby     = (k % 613) == 612;
            cycle("sweep R7 R9 R12");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule